// File: doc/BRIEF.md
# Dual-Issue Pair Hazard Checker

This block judges a pair of already-decoded instructions, presented in program order as an earlier slot (A) and a later slot (B). It reports whether both may go out together in one wide instruction word or whether they must run one after the other. Each slot describes its register writes, including a paired write to an even/odd register couple. It also gives up to three register reads, the flags it reads and writes, its class, its execution condition and an optional post-modified base register. A flag marks the packed-halfword operations that may not share a word with a memory access.

All hazard rules are evaluated side by side. Each rule raises its own bit in a reason mask, and the pair is allowed in parallel only when the mask is clear. One pair is taken per cycle through a valid/ready handshake, and the verdict appears registered one cycle later. Decoding, reordering and NOP insertion belong to the surrounding issue logic.

Top module: `pair_hazard_chk`

## Requirements
- R1: If A writes a general register (its destination, or destination+1 when the pair bit is set) that B reads through any enabled source, reason bit 0 (read-after-write) is set.
- R2: If the register sets written by A and by B overlap, counting destination+1 for paired writes, reason bit 1 (write-after-write) is set.
- R3: A register that B writes and A only reads causes no reason bit; with no other rule hit, the verdict is parallel.
- R4: When both slots have class load (2) or store (3), reason bit 2 (memory) is set, whatever the mix of loads and stores.
- R5: Reason bit 3 (flag) is set when A writes a flag that B reads, or when either slot writes the carry flag (flag bit 7) while the other reads or writes it; writes to different non-carry flags alone set nothing.
- R6: Reason bit 4 (condition) is set when B's condition code is non-zero (1 to 6 select tests on F0, F1 or both) and A writes flag bit 0 or bit 1; condition code 0 means always-execute and never sets it.
- R7: If A has class branch (4), reason bit 5 (branch) is set; a branch in slot B alone sets nothing.
- R8: A post-modified base register in A counts as a write by A, so B reading it sets reason bit 0; a post-modified base in B creates no hazard with A's reads.
- R9: Register 0 never takes part in a hazard: writing or reading it sets neither bit 0 nor bit 1.
- R10: Reason bit 6 (prohibited pair) is set when one slot is a load or store and the other has the packed-halfword flag set; several bits may be set together, and the parallel output is 1 only when all seven reason bits are 0.
- R11: After reset the output is invalid and ready is high; a pair accepted on a clock edge appears on the output after that edge; ready is high whenever the output is empty or being taken, so pairs are accepted every cycle; a held output keeps its verdict stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Pair offered |
| in_ready | output | 1 | Pair can be taken this cycle |
| a_cls | input | 3 | Slot A class: 0 ALU, 1 multiply, 2 load, 3 store, 4 branch |
| a_dst | input | 6 | Slot A destination register |
| a_dst_en | input | 1 | Slot A writes a register |
| a_dst_pair | input | 1 | Slot A also writes destination+1 |
| a_src | input | 18 | Slot A three source registers, source k at bits 6k+5:6k |
| a_src_en | input | 3 | Slot A source enables |
| a_flg_rd | input | 8 | Slot A flags read (bit 0 F0, bit 1 F1, bit 7 carry) |
| a_flg_wr | input | 8 | Slot A flags written |
| a_cond | input | 3 | Slot A condition code, 0 always |
| a_pm_en | input | 1 | Slot A post-modifies a base register |
| a_pm_reg | input | 6 | Slot A post-modified base register |
| a_packed | input | 1 | Slot A is a packed-halfword operation |
| b_cls | input | 3 | Slot B class |
| b_dst | input | 6 | Slot B destination register |
| b_dst_en | input | 1 | Slot B writes a register |
| b_dst_pair | input | 1 | Slot B also writes destination+1 |
| b_src | input | 18 | Slot B source registers |
| b_src_en | input | 3 | Slot B source enables |
| b_flg_rd | input | 8 | Slot B flags read |
| b_flg_wr | input | 8 | Slot B flags written |
| b_cond | input | 3 | Slot B condition code |
| b_pm_en | input | 1 | Slot B post-modifies a base register |
| b_pm_reg | input | 6 | Slot B post-modified base register |
| b_packed | input | 1 | Slot B is a packed-halfword operation |
| out_valid | output | 1 | Verdict present |
| out_ready | input | 1 | Consumer takes the verdict |
| out_par | output | 1 | Pair may issue in parallel |
| out_reason | output | 7 | Hazard mask: 0 RAW, 1 WAW, 2 memory, 3 flag, 4 condition, 5 branch, 6 prohibited |

## Verification
Pairs are built so that each one hits exactly one rule, with a near-miss beside it that must stay parallel. Examples are a write-after-read overlap against a true read-after-write, the post-modified base in A against the same base in B, a branch in A against a branch in B, and an unconditional consumer of a fresh compare against a conditional one. These cases separate each reason bit from its neighbours. Paired-register writes are tried against both the low and the high register, which shows that destination+1 is counted. One pair hits two rules together, which shows that the bits are evaluated independently. The same set is then replayed with the consumer stalling in a repeating pattern, which separates correct holding and back-pressure from plain one-cycle forwarding.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int REG_W     = 6;
    localparam int NSRC      = 3;
    localparam int NFLAG     = 8;
    localparam int F0_BIT    = 0;
    localparam int F1_BIT    = 1;
    localparam int CARRY_BIT = 7;
    localparam int COND_W    = 3;
    localparam int CLS_W     = 3;

    localparam int RSN_RAW  = 0;
    localparam int RSN_WAW  = 1;
    localparam int RSN_MEM  = 2;
    localparam int RSN_FLAG = 3;
    localparam int RSN_COND = 4;
    localparam int RSN_BR   = 5;
    localparam int RSN_PROH = 6;
    localparam int RSN_W    = 7;

    typedef enum logic [CLS_W-1:0] {
        CLS_ALU   = 3'd0,
        CLS_MUL   = 3'd1,
        CLS_LOAD  = 3'd2,
        CLS_STORE = 3'd3,
        CLS_BR    = 3'd4
    } cls_e;

    typedef struct packed {
        cls_e                    cls;
        logic [REG_W-1:0]        dst;
        logic                    dst_en;
        logic                    dst_pair;
        logic [NSRC*REG_W-1:0]   src;
        logic [NSRC-1:0]         src_en;
        logic [NFLAG-1:0]        flg_rd;
        logic [NFLAG-1:0]        flg_wr;
        logic [COND_W-1:0]       cond;
        logic                    pm_en;
        logic [REG_W-1:0]        pm_reg;
        logic                    packed_op;
    } slot_t;

    typedef struct packed {
        logic             valid;
        logic             par;
        logic [RSN_W-1:0] reason;
    } out_t;
endpackage

// File: rtl/hz_reg_dep.sv
module hz_reg_dep
    import hz_pkg::*;
(
    input  slot_t a,
    input  slot_t b,
    output logic  raw,
    output logic  waw
);
    localparam logic [REG_W-1:0] ONE = {{(REG_W-1){1'b0}}, 1'b1};

    logic [REG_W-1:0] a_hi, b_hi;
    logic [NSRC-1:0]  src_hit;

    assign a_hi = a.dst + ONE;
    assign b_hi = b.dst + ONE;

    // register r is written by slot A (destination, pair partner or last-stage base update)
    function automatic logic a_writes(input slot_t s, input logic [REG_W-1:0] hi,
                                      input logic [REG_W-1:0] r);
        logic w;
        w = (s.dst_en && (r == s.dst || (s.dst_pair && r == hi)))
            || (s.pm_en && r == s.pm_reg);
        return w && (r != '0);
    endfunction

    generate
        for (genvar k = 0; k < NSRC; k++) begin : g_src
            assign src_hit[k] = b.src_en[k] && a_writes(a, a_hi, b.src[k*REG_W +: REG_W]);
        end
    endgenerate

    always_comb begin
        raw = |src_hit;
        waw = 1'b0;
        if (b.dst_en) begin
            waw = a_writes(a, a_hi, b.dst)
                  || (b.dst_pair && a_writes(a, a_hi, b_hi));
        end
    end
endmodule

// File: rtl/hz_flag_cond.sv
module hz_flag_cond
    import hz_pkg::*;
(
    input  slot_t a,
    input  slot_t b,
    output logic  flag_hz,
    output logic  cond_hz
);
    logic a_cw, a_cr, b_cw, b_cr;

    always_comb begin
        a_cw    = a.flg_wr[CARRY_BIT];
        a_cr    = a.flg_rd[CARRY_BIT];
        b_cw    = b.flg_wr[CARRY_BIT];
        b_cr    = b.flg_rd[CARRY_BIT];
        flag_hz = (|(a.flg_wr & b.flg_rd))
                  || (a_cw && (b_cr || b_cw))
                  || (b_cw && a_cr);
        cond_hz = (b.cond != '0) && (a.flg_wr[F0_BIT] || a.flg_wr[F1_BIT]);
    end
endmodule

// File: rtl/hz_class_rule.sv
module hz_class_rule
    import hz_pkg::*;
(
    input  slot_t a,
    input  slot_t b,
    output logic  mem_hz,
    output logic  br_hz,
    output logic  proh_hz
);
    logic a_mem, b_mem;

    always_comb begin
        a_mem   = (a.cls == CLS_LOAD) || (a.cls == CLS_STORE);
        b_mem   = (b.cls == CLS_LOAD) || (b.cls == CLS_STORE);
        mem_hz  = a_mem && b_mem;
        br_hz   = (a.cls == CLS_BR);
        proh_hz = (a_mem && b.packed_op) || (b_mem && a.packed_op);
    end
endmodule

// File: rtl/pair_hazard_chk.sv
module pair_hazard_chk
    import hz_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [CLS_W-1:0]      a_cls,
    input  logic [REG_W-1:0]      a_dst,
    input  logic                  a_dst_en,
    input  logic                  a_dst_pair,
    input  logic [NSRC*REG_W-1:0] a_src,
    input  logic [NSRC-1:0]       a_src_en,
    input  logic [NFLAG-1:0]      a_flg_rd,
    input  logic [NFLAG-1:0]      a_flg_wr,
    input  logic [COND_W-1:0]     a_cond,
    input  logic                  a_pm_en,
    input  logic [REG_W-1:0]      a_pm_reg,
    input  logic                  a_packed,
    input  logic [CLS_W-1:0]      b_cls,
    input  logic [REG_W-1:0]      b_dst,
    input  logic                  b_dst_en,
    input  logic                  b_dst_pair,
    input  logic [NSRC*REG_W-1:0] b_src,
    input  logic [NSRC-1:0]       b_src_en,
    input  logic [NFLAG-1:0]      b_flg_rd,
    input  logic [NFLAG-1:0]      b_flg_wr,
    input  logic [COND_W-1:0]     b_cond,
    input  logic                  b_pm_en,
    input  logic [REG_W-1:0]      b_pm_reg,
    input  logic                  b_packed,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic                  out_par,
    output logic [RSN_W-1:0]      out_reason
);
    slot_t            sa, sb;
    logic             raw, waw, flag_hz, cond_hz, mem_hz, br_hz, proh_hz;
    logic [RSN_W-1:0] reason_c;
    out_t             out_d, out_q;

    assign sa = '{cls: cls_e'(a_cls), dst: a_dst, dst_en: a_dst_en, dst_pair: a_dst_pair,
                  src: a_src, src_en: a_src_en, flg_rd: a_flg_rd, flg_wr: a_flg_wr,
                  cond: a_cond, pm_en: a_pm_en, pm_reg: a_pm_reg, packed_op: a_packed};
    assign sb = '{cls: cls_e'(b_cls), dst: b_dst, dst_en: b_dst_en, dst_pair: b_dst_pair,
                  src: b_src, src_en: b_src_en, flg_rd: b_flg_rd, flg_wr: b_flg_wr,
                  cond: b_cond, pm_en: b_pm_en, pm_reg: b_pm_reg, packed_op: b_packed};

    hz_reg_dep    u_reg  (.a(sa), .b(sb), .raw(raw), .waw(waw));
    hz_flag_cond  u_flag (.a(sa), .b(sb), .flag_hz(flag_hz), .cond_hz(cond_hz));
    hz_class_rule u_cls  (.a(sa), .b(sb), .mem_hz(mem_hz), .br_hz(br_hz), .proh_hz(proh_hz));

    always_comb begin
        reason_c           = '0;
        reason_c[RSN_RAW]  = raw;
        reason_c[RSN_WAW]  = waw;
        reason_c[RSN_MEM]  = mem_hz;
        reason_c[RSN_FLAG] = flag_hz;
        reason_c[RSN_COND] = cond_hz;
        reason_c[RSN_BR]   = br_hz;
        reason_c[RSN_PROH] = proh_hz;
    end

    assign in_ready = !out_q.valid || out_ready;

    always_comb begin
        out_d = out_q;
        if (in_valid && in_ready) begin
            out_d.valid  = 1'b1;
            out_d.reason = reason_c;
            out_d.par    = (reason_c == '0);
        end else if (out_ready) begin
            out_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid  = out_q.valid;
    assign out_par    = out_q.par;
    assign out_reason = out_q.reason;

    // R11: a held verdict must not change
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_reason) && $stable(out_par));
    // R11: an empty output stage always accepts
    p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);
    // R7: a leading branch is never paired
    p_branch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && a_cls == CLS_BR |=> out_valid && !out_par && out_reason[RSN_BR]);
    // R4: two memory operations are never paired
    p_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && (a_cls == CLS_LOAD || a_cls == CLS_STORE)
        && (b_cls == CLS_LOAD || b_cls == CLS_STORE) |=> out_reason[RSN_MEM] && !out_par);
    // R6: an always-execute slot B never raises the condition bit
    p_cond_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && b_cond == '0 |=> !out_reason[RSN_COND]);
    // R10: parallel verdict only with an empty mask
    p_par_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_par |-> out_reason == '0);
endmodule

// File: tb/pair_hazard_chk_tb_top.sv
module pair_hazard_chk_tb_top;
    localparam int RAW = 0, WAW = 1, MEM = 2, FLG = 3, CND = 4, BR = 5, PRH = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_ready;
    logic [2:0] a_cls, b_cls, a_cond, b_cond, a_src_en, b_src_en;
    logic [5:0] a_dst, b_dst, a_pm_reg, b_pm_reg;
    logic a_dst_en, b_dst_en, a_dst_pair, b_dst_pair, a_pm_en, b_pm_en, a_packed, b_packed;
    logic [17:0] a_src, b_src;
    logic [7:0] a_flg_rd, a_flg_wr, b_flg_rd, b_flg_wr;
    logic out_valid, out_ready = 1'b1, out_par;
    logic [6:0] out_reason;

    int total = 0, bad = 0, cyc = 0;
    bit stall_mode = 1'b0, done = 1'b0;
    logic [7:0] exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pair_hazard_chk dut_i (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr();
        {a_cls, a_dst, a_dst_en, a_dst_pair, a_src, a_src_en, a_flg_rd, a_flg_wr,
         a_cond, a_pm_en, a_pm_reg, a_packed} = '0;
        {b_cls, b_dst, b_dst_en, b_dst_pair, b_src, b_src_en, b_flg_rd, b_flg_wr,
         b_cond, b_pm_en, b_pm_reg, b_packed} = '0;
    endtask

    task automatic asrc(input int k, input logic [5:0] r);
        a_src[k*6 +: 6] = r; a_src_en[k] = 1'b1;
    endtask
    task automatic bsrc(input int k, input logic [5:0] r);
        b_src[k*6 +: 6] = r; b_src_en[k] = 1'b1;
    endtask
    task automatic adst(input logic [5:0] r, input bit pr);
        a_dst = r; a_dst_en = 1'b1; a_dst_pair = pr;
    endtask
    task automatic bdst(input logic [5:0] r, input bit pr);
        b_dst = r; b_dst_en = 1'b1; b_dst_pair = pr;
    endtask

    // driver: offers the pair set up by the caller until it is accepted
    task automatic send(input logic [6:0] exp_rsn, input string tag);
        bit acc;
        acc = 1'b0;
        while (!acc) begin
            out_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
            in_valid  = 1'b1;
            #1;
            if (out_valid && !out_ready)
                check(!in_ready, "R11 ready low while held", in_ready, 0);
            acc = in_ready;
            @(posedge clk);
            if (acc) begin
                exp_q.push_back({exp_rsn == 7'd0, exp_rsn});
                tag_q.push_back(tag);
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    // monitor: compares each verdict taken by the consumer
    always @(negedge clk) begin
        #2;
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected output", {out_par, out_reason}, 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({out_par, out_reason} == e, t, {out_par, out_reason}, e);
            end
        end
    end

    task automatic run_set();
        clr(); adst(1, 0); bsrc(1, 1); send(7'(1 << RAW), "R1 raw on dst");
        clr(); adst(1, 0); bdst(4, 0); bsrc(0, 3); send(7'd0, "R1 independent");
        clr(); a_cls = 3'd2; adst(4, 1); asrc(0, 6); bdst(5, 0); bsrc(0, 19);
        send(7'(1 << WAW), "R2 waw on pair high");
        clr(); a_cls = 3'd2; adst(4, 1); asrc(0, 6); bdst(3, 0); bsrc(1, 5);
        send(7'(1 << RAW), "R2 raw on pair high");
        clr(); a_cls = 3'd2; adst(4, 1); asrc(0, 6); bdst(6, 0); bsrc(0, 19);
        send(7'd0, "R3 war allowed");
        clr(); a_cls = 3'd3; asrc(0, 7); asrc(1, 8); b_cls = 3'd2; bdst(1, 0); bsrc(0, 2);
        send(7'(1 << MEM), "R4 store then load");
        clr(); a_cls = 3'd2; adst(7, 0); b_cls = 3'd2; bdst(1, 0);
        send(7'(1 << MEM), "R4 load then load");
        clr(); a_flg_wr = 8'h80; b_flg_wr = 8'h80; send(7'(1 << FLG), "R5 both write carry");
        clr(); a_flg_rd = 8'h80; b_flg_wr = 8'h80; send(7'(1 << FLG), "R5 read then write carry");
        clr(); a_flg_wr = 8'h01; b_flg_wr = 8'h02; send(7'd0, "R5 distinct flags");
        clr(); a_flg_wr = 8'h01; b_cls = 3'd4; b_cond = 3'd1; send(7'(1 << CND), "R6 cond on F0");
        clr(); a_flg_wr = 8'h02; b_cls = 3'd4; b_cond = 3'd6; send(7'(1 << CND), "R6 cond F1 writer");
        clr(); a_flg_wr = 8'h01; b_cls = 3'd4; send(7'd0, "R6 unconditional");
        clr(); a_cls = 3'd4; bdst(1, 0); send(7'(1 << BR), "R7 leading branch");
        clr(); adst(1, 0); b_cls = 3'd4; send(7'd0, "R7 trailing branch");
        clr(); a_cls = 3'd2; adst(4, 0); a_pm_en = 1; a_pm_reg = 6; bdst(9, 0); bsrc(0, 6);
        send(7'(1 << RAW), "R8 post-mod first");
        clr(); adst(9, 0); asrc(0, 6); b_cls = 3'd2; bdst(4, 0); bsrc(0, 6); bsrc(1, 11);
        b_pm_en = 1; b_pm_reg = 6; send(7'd0, "R8 post-mod second");
        clr(); adst(0, 0); bdst(0, 0); bsrc(0, 0); send(7'd0, "R9 register zero");
        clr(); a_cls = 3'd3; asrc(0, 2); bdst(4, 0); b_packed = 1; send(7'(1 << PRH), "R10 store with packed");
        clr(); a_cls = 3'd1; a_packed = 1; adst(22, 0); b_cls = 3'd2; bdst(19, 0);
        send(7'(1 << PRH), "R10 packed with load");
        clr(); a_packed = 1; adst(2, 0); bdst(3, 0); send(7'd0, "R10 packed alu pair");
        clr(); a_cls = 3'd4; adst(1, 0); bsrc(2, 1); send(7'((1 << RAW) | (1 << BR)), "R10 two bits");
    endtask

    initial begin
        clr();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!out_valid, "R11 reset valid", out_valid, 0);
        check(in_ready, "R11 reset ready", in_ready, 1);
        run_set();
        stall_mode = 1'b1;
        run_set();
        stall_mode = 1'b0;
        out_ready = 1'b1;
        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R11 drained", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule